// File: doc/BRIEF.md
# Strobe-Latched Synthesizer Divider Chain

This block is the counting part of an integer-N frequency synthesizer. It runs from one fast RF clock. An RF divide word N, a reference divide word R and a two-bit phase-detector gain code come in on a parallel bus. While the strobe input is high, these words pass into holding registers. Once the strobe drops, the registers are frozen and counting begins. Holding the strobe high also parks every counter at zero and turns off the charge-pump enable.

The RF path is a fixed divide-by-8 prescaler followed by a programmable divide-by-N stage. Its output pulse lasts one whole prescaler period. The reference path samples a slower reference signal, counts its rising edges and passes every R-th high phase to the output. A direction input chooses which of the two output pins carries each divided signal. An output-enable input can force both pins low. Outside the block, a charge pump and a loop filter close the loop.

Top module: `synth_divchain`

## Requirements
- R1: The holding registers follow the input words on every clock edge at which strobe is high and keep their value while strobe is low. A word changed while strobe is low changes neither gain_q nor the division in progress.
- R2: On every clock edge at which strobe is high, all counters return to zero. After that edge, cp_en, out_a and out_b are all 0.
- R3: On the first edge at which strobe is low after being high, gain_q takes the gain code held in the holding register. After every edge at which strobe is low, cp_en is 1.
- R4: Number the edges from k = 0 at the first edge with strobe low. After edge k, the RF pulse is high exactly when floor(k/8) mod N equals N-1. This gives a period of 8·N cycles and a pulse width of 8 cycles.
- R5: An RF word of 0 divides in the same way as N = 1, so the RF pulse stays high the whole time counting is active.
- R6: The reference input passes through one sampling register. Each rising edge of the sampled value seen on an edge with strobe low is counted. The pulses belonging to the R-th, 2R-th and later rising edges reach the output for as long as the sampled value stays high. R = 0 behaves as R = 1.
- R7: After any edge at which out_en is 0, both out_a and out_b are 0.
- R8: When dir is 1, out_a carries the RF pulse and out_b carries the reference pulse. When dir is 0, the two are swapped. All outputs are registered and follow their inputs by one edge.
- R9: After reset, cp_en, out_a and out_b are 0, gain_q is 2'b11 and the holding registers are all ones. All ones is the idle state of an undriven input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | High: buffers transparent and counters held; low: run |
| rf_word | input | 14 | RF programmable divide word N |
| ref_word | input | 10 | Reference divide word R |
| gain_code | input | 2 | Phase-detector gain code |
| out_en | input | 1 | Enables both divided-pulse outputs |
| dir | input | 1 | Selects which pin carries the RF pulse |
| ref_in | input | 1 | Reference signal, slower than clk |
| out_a | output | 1 | RF pulse when dir=1, reference pulse when dir=0 |
| out_b | output | 1 | Reference pulse when dir=1, RF pulse when dir=0 |
| cp_en | output | 1 | Charge-pump enable |
| gain_q | output | 2 | Gain code in effect |

## Verification
Two events can fall on the same edge. First, the strobe can drop on the very edge at which the sampled reference rises, so that rising edge is counted by a counter that is only just being released. Second, the strobe can rise while an RF pulse or a reference pulse is active, and the hold has to cut that pulse off on the same edge. The bench makes both happen by running a free reference waveform whose period shares no factor with the strobe timing, and by raising the strobe in the middle of a count. Each case is judged edge by edge against a behavioural model that counts edges since the strobe fell.

// File: rtl/divchain_pkg.sv
`timescale 1ns/1ps
package divchain_pkg;
  localparam int RF_W_DEF   = 14;
  localparam int REF_W_DEF  = 10;
  localparam int GAIN_W_DEF = 2;
  localparam int PRE_BITS_DEF = 3;
endpackage

// File: rtl/divchain_ctrl.sv
`timescale 1ns/1ps
module divchain_ctrl #(
  parameter int RF_W   = divchain_pkg::RF_W_DEF,
  parameter int REF_W  = divchain_pkg::REF_W_DEF,
  parameter int GAIN_W = divchain_pkg::GAIN_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [RF_W-1:0]   rf_word,
  input  logic [REF_W-1:0]  ref_word,
  input  logic [GAIN_W-1:0] gain_code,
  output logic [RF_W-1:0]   rf_hold,
  output logic [REF_W-1:0]  ref_hold,
  output logic [GAIN_W-1:0] gain_q,
  output logic              cp_en
);
  logic [GAIN_W-1:0] gain_hold;
  logic              strobe_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_hold   <= '1;
      ref_hold  <= '1;
      gain_hold <= '1;
      gain_q    <= '1;
      cp_en     <= 1'b0;
      strobe_d  <= 1'b1;
    end else begin
      strobe_d <= strobe;
      cp_en    <= ~strobe;
      if (strobe) begin
        rf_hold   <= rf_word;
        ref_hold  <= ref_word;
        gain_hold <= gain_code;
      end
      if (!strobe && strobe_d) gain_q <= gain_hold;
    end
  end
endmodule

// File: rtl/divchain_rf.sv
`timescale 1ns/1ps
module divchain_rf #(
  parameter int RF_W     = divchain_pkg::RF_W_DEF,
  parameter int PRE_BITS = divchain_pkg::PRE_BITS_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic [RF_W-1:0] word,
  output logic            hit
);
  localparam logic [PRE_BITS-1:0] PRE_TOP = '1;

  logic [PRE_BITS-1:0] pre;
  logic [RF_W-1:0]     ncnt;
  logic [RF_W-1:0]     last;

  assign last = (word == '0) ? '0 : word - 1'b1;
  assign hit  = (ncnt == last);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      pre  <= '0;
      ncnt <= '0;
    end else begin
      pre <= pre + 1'b1;
      if (pre == PRE_TOP) ncnt <= (ncnt >= last) ? '0 : ncnt + 1'b1;
    end
  end
endmodule

// File: rtl/divchain_ref.sv
`timescale 1ns/1ps
module divchain_ref #(
  parameter int REF_W = divchain_pkg::REF_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             ref_in,
  input  logic [REF_W-1:0] word,
  output logic             hit
);
  logic             ref_s, ref_d, tc;
  logic [REF_W-1:0] rcnt;
  logic [REF_W-1:0] last;
  logic             rise, at_last, tc_now;

  assign last    = (word == '0) ? '0 : word - 1'b1;
  assign rise    = ref_s & ~ref_d;
  assign at_last = (rcnt >= last);
  assign tc_now  = rise ? at_last : tc;
  assign hit     = ref_s & tc_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_s <= 1'b0;
      ref_d <= 1'b0;
    end else begin
      ref_s <= ref_in;
      ref_d <= ref_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      rcnt <= '0;
      tc   <= 1'b0;
    end else if (rise) begin
      tc   <= at_last;
      rcnt <= at_last ? '0 : rcnt + 1'b1;
    end
  end
endmodule

// File: rtl/synth_divchain.sv
`timescale 1ns/1ps
module synth_divchain #(
  parameter int RF_W     = divchain_pkg::RF_W_DEF,
  parameter int REF_W    = divchain_pkg::REF_W_DEF,
  parameter int GAIN_W   = divchain_pkg::GAIN_W_DEF,
  parameter int PRE_BITS = divchain_pkg::PRE_BITS_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [RF_W-1:0]   rf_word,
  input  logic [REF_W-1:0]  ref_word,
  input  logic [GAIN_W-1:0] gain_code,
  input  logic              out_en,
  input  logic              dir,
  input  logic              ref_in,
  output logic              out_a,
  output logic              out_b,
  output logic              cp_en,
  output logic [GAIN_W-1:0] gain_q
);
  logic [RF_W-1:0]  rf_hold;
  logic [REF_W-1:0] ref_hold;
  logic             rf_hit, ref_hit, live;

  divchain_ctrl #(.RF_W(RF_W), .REF_W(REF_W), .GAIN_W(GAIN_W)) i_ctrl (
    .clk(clk), .rst(rst), .strobe(strobe), .rf_word(rf_word),
    .ref_word(ref_word), .gain_code(gain_code), .rf_hold(rf_hold),
    .ref_hold(ref_hold), .gain_q(gain_q), .cp_en(cp_en)
  );

  divchain_rf #(.RF_W(RF_W), .PRE_BITS(PRE_BITS)) i_rf (
    .clk(clk), .rst(rst), .hold(strobe), .word(rf_hold), .hit(rf_hit)
  );

  divchain_ref #(.REF_W(REF_W)) i_ref (
    .clk(clk), .rst(rst), .hold(strobe), .ref_in(ref_in),
    .word(ref_hold), .hit(ref_hit)
  );

  assign live = out_en & ~strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else begin
      out_a <= live & (dir ? rf_hit : ref_hit);
      out_b <= live & (dir ? ref_hit : rf_hit);
    end
  end
endmodule

// File: rtl/divchain_chk.sv
`timescale 1ns/1ps
module divchain_chk #(
  parameter int GAIN_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe,
  input logic              out_en,
  input logic              out_a,
  input logic              out_b,
  input logic              cp_en,
  input logic [GAIN_W-1:0] gain_q
);
  logic strobe_q;
  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b1;
    else     strobe_q <= strobe;
  end

  AST_HOLD_CP_OFF: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !cp_en); // R2
  AST_HOLD_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (!out_a && !out_b)); // R2
  AST_RUN_CP_ON: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> cp_en); // R3
  AST_GAIN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !strobe_q) |=> $stable(gain_q)); // R1
  AST_OE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (!out_a && !out_b)); // R7
endmodule

bind synth_divchain divchain_chk #(.GAIN_W(GAIN_W)) i_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .out_en(out_en), .out_a(out_a),
  .out_b(out_b), .cp_en(cp_en), .gain_q(gain_q)
);

// File: tb/test_synth_divchain.sv
`timescale 1ns/1ps
module test_synth_divchain;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe = 1'b1;
  logic [13:0] rf_word = '1;
  logic [9:0]  ref_word = '1;
  logic [1:0]  gain_code = '1;
  logic        out_en = 1'b1;
  logic        dir = 1'b1;
  logic        ref_in = 1'b0;
  logic        out_a, out_b, cp_en;
  logic [1:0]  gain_q;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  synth_divchain i_synth_divchain (
    .clk(clk), .rst(rst), .strobe(strobe), .rf_word(rf_word),
    .ref_word(ref_word), .gain_code(gain_code), .out_en(out_en), .dir(dir),
    .ref_in(ref_in), .out_a(out_a), .out_b(out_b), .cp_en(cp_en),
    .gain_q(gain_q)
  );

  // free-running reference: period 7 cycles, high for 3
  int rph = 0;
  always @(negedge clk) begin
    rph = (rph + 1) % 7;
    ref_in <= (rph < 3);
  end

  // behavioural model: edges since the strobe fell, rising-edge tally
  int   k = 0, rc = 0;
  logic mtc = 0, ms = 0, md = 0, mprev = 1, valid = 0;
  int   mbuf_n = 16383, mbuf_r = 1023, mbuf_g = 3;
  logic exp_a = 0, exp_b = 0, exp_cp = 0;
  int   exp_g = 3;

  always @(posedge clk) begin
    if (rst) begin
      k = 0; rc = 0; mtc = 0; ms = 0; md = 0; mprev = 1; valid = 1;
      mbuf_n = 16383; mbuf_r = 1023; mbuf_g = 3;
      exp_a = 0; exp_b = 0; exp_cp = 0; exp_g = 3;
    end else begin
      int nv, rl;
      logic rfp, rise, tcn, refp;
      nv   = (mbuf_n == 0) ? 1 : mbuf_n;
      rl   = (mbuf_r == 0) ? 0 : mbuf_r - 1;
      rfp  = ((k / 8) % nv) == nv - 1;
      rise = ms && !md;
      tcn  = rise ? (rc >= rl) : mtc;
      refp = ms && tcn;
      exp_a  = out_en && !strobe && (dir ? rfp : refp);
      exp_b  = out_en && !strobe && (dir ? refp : rfp);
      exp_cp = !strobe;
      if (!strobe && mprev) exp_g = mbuf_g;
      if (strobe) begin
        k = 0; rc = 0; mtc = 0;
        mbuf_n = rf_word; mbuf_r = ref_word; mbuf_g = gain_code;
      end else begin
        k++;
        if (rise) begin
          mtc = (rc >= rl);
          rc  = (rc >= rl) ? 0 : rc + 1;
        end
      end
      mprev = strobe;
      md = ms; ms = ref_in;
    end
  end

  always @(negedge clk) begin
    if (valid && !rst) begin
      checks++;
      if (out_a !== exp_a || out_b !== exp_b || cp_en !== exp_cp || gain_q !== 2'(exp_g)) begin
        fails++;
        $display("FAIL R2/R3/R4/R6/R8 cycle compare: a=%0b b=%0b cp=%0b g=%0d expected a=%0b b=%0b cp=%0b g=%0d",
                 out_a, out_b, cp_en, gain_q, exp_a, exp_b, exp_cp, exp_g);
      end
    end
  end

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int hi, rises, run, maxrun, any;
    logic prev;
    repeat (3) @(negedge clk);
    check("R9 cp_en", cp_en, 0);
    check("R9 outputs", out_a | out_b, 0);
    check("R9 gain_q", gain_q, 3);
    rst = 1'b0;

    // scenario A: N=3, R=2, dir=1
    rf_word = 3; ref_word = 2; gain_code = 1; dir = 1;
    repeat (3) @(negedge clk);
    check("R2 cp_en held", cp_en, 0);
    strobe = 1'b0;
    hi = 0; rises = 0; prev = 0; run = 0; maxrun = 0;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (i == 0) begin
        check("R3 gain load", gain_q, 1);
        check("R3 cp_en", cp_en, 1);
      end
      if (out_a) hi++;
      if (out_a && !prev) rises++;
      prev = out_a;
      run = out_b ? run + 1 : 0;
      if (run > maxrun) maxrun = run;
    end
    check("R4 width total", hi, 16);
    check("R4 pulse count", rises, 2);
    check("R6 pulse width", maxrun, 3);
    gain_code = 2; rf_word = 7;
    repeat (24) @(negedge clk);
    check("R1 gain frozen", gain_q, 1);

    // scenario B: N=2, R=0, dir=0, strobe held
    strobe = 1'b1; rf_word = 2; ref_word = 0; dir = 0;
    any = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      any += out_a + out_b + cp_en;
    end
    check("R2 quiet while held", any, 0);
    strobe = 1'b0;
    hi = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (out_b) hi++;
    end
    check("R8 rf on out_b", hi, 16);

    // scenario C: outputs disabled
    out_en = 1'b0;
    any = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      any += out_a + out_b;
    end
    check("R7 disabled", any, 0);
    out_en = 1'b1;

    // scenario D: N=0, R=3, dir=1
    strobe = 1'b1; rf_word = 0; ref_word = 3; dir = 1;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (out_a) hi++;
    end
    check("R5 N=0 constant", hi, 40);

    // scenario E: strobe raised mid-count, then released
    strobe = 1'b1; rf_word = 4; ref_word = 1;
    repeat (2) @(negedge clk);
    strobe = 1'b0;
    repeat (21) @(negedge clk);
    strobe = 1'b1;
    @(negedge clk);
    check("R2 hold cuts pulse", out_a | out_b, 0);
    strobe = 1'b0;
    repeat (60) @(negedge clk);
    finish_run();
  end
endmodule